// File: doc/BRIEF.md
# Foreign memory-map address translator

This block sits on the cartridge side of a 6502-style CPU bus. It lets program code written for a different home computer run without change. For every CPU address it decides, in the same cycle, where the access goes. The choices are a relocated program RAM, an emulated video-chip register file, the plain RAM that lies behind that register window, or nothing at all. It then drives the matching one-hot select, the physical address and a write enable toward the internal memories.

A small control byte written by the CPU turns the translation on and sets a three-bit memory-configuration field. Only the top bit of that field, the I/O-window switch, changes routing. Once translation is on, the control address is taken over by the relocated RAM, so the setting stays in place until the next reset. Writes reach the memories directly, with no buffering and no handshake.

Top module: `memmap_xlate`

## Requirements
- R1: After reset `cfg_o` reads 4'b0000, every address routes to the none select (`sel_o`=4'b1000) with `phys_addr_o` equal to `cpu_addr_i`, and `we_o` stays 0.
- R2: With translation on, CPU addresses $0800 to $97FF select program RAM (`sel_o`=4'b0001) with `phys_addr_o` = address + $5800, so $0800 maps to $6000 and $97FF maps to $EFFF.
- R3: With translation on, addresses $0000-$07FF, $9800-$CFFF and $E000-$FFFF select none (`sel_o`=4'b1000) with `phys_addr_o` equal to the CPU address.
- R4: With translation on and the I/O switch (`cfg_o[3]`) set, $D000-$DFFF selects the register file (`sel_o`=4'b0010). `phys_addr_o` carries the low 6 address bits with all upper bits zero, so every 64-byte block mirrors $D000-$D03F.
- R5: With translation on and `cfg_o[3]` clear, $D000-$DFFF selects I/O RAM (`sel_o`=4'b0100) with `phys_addr_o` equal to the CPU address.
- R6: `we_o` equals `cpu_we_i` in the same cycle whenever the select is not none, and is 0 when it is none.
- R7: While translation is off, a write to $6000 loads the control register. From the next cycle `cfg_o` reads {data bit 2 (I/O switch), data bit 1, data bit 0, data bit 0 (translate enable)}, so writing $05 gives 4'b1011.
- R8: While translation is on, a write to $6000 goes to program RAM at physical $B800 and leaves `cfg_o` unchanged.
- R9: While translation is off, writes to any address other than $6000 leave `cfg_o` unchanged.
- R10: The stored LORAM and HIRAM bits (`cfg_o[2:1]`) read back as written and have no effect on select or physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| sel_o | output | 4 | One-hot target: bit0 program RAM, bit1 register file, bit2 I/O RAM, bit3 none |
| phys_addr_o | output | 16 | Physical address for the selected target |
| we_o | output | 1 | Write enable to the selected target |
| cfg_o | output | 4 | Readback: bit0 translate enable, bit1 LORAM, bit2 HIRAM, bit3 I/O switch |

## Verification
The assertions assume the CPU address and write strobe are settled at each sampling edge. They treat the routing outputs as pure functions of those inputs and of the stored configuration, so glitches between edges are not checked. The stimulus changes inputs only on the falling edge. It aims random addresses at the region edges as well as across the full space, and it enters each configuration only through a real control write after reset, never by forcing state.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int unsigned SEL_W = 4;
  typedef enum logic [SEL_W-1:0] {
    SEL_PRG  = 4'b0001,
    SEL_VREG = 4'b0010,
    SEL_IORAM = 4'b0100,
    SEL_NONE = 4'b1000
  } sel_e;
endpackage

// File: rtl/memmap_cfg_reg.sv
module memmap_cfg_reg #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h6000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              xlate_en_o,
  output logic [2:0]        memcfg_o
);
  logic ctrl_hit;
  logic unused_wdata;

  // control byte only reachable before translation takes the address over
  assign ctrl_hit = !xlate_en_o && cpu_we_i && (cpu_addr_i == CTRL_ADDR);
  assign unused_wdata = ^cpu_wdata_i[DATA_W-1:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xlate_en_o <= 1'b0;
      memcfg_o   <= '0;
    end else if (ctrl_hit) begin
      xlate_en_o <= cpu_wdata_i[0];
      memcfg_o   <= cpu_wdata_i[2:0];
    end
  end
endmodule

// File: rtl/memmap_route.sv
module memmap_route
  import memmap_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PRG_LO = 16'h0800,
  parameter logic [ADDR_W-1:0] PRG_OFS = 16'h5800,
  parameter logic [ADDR_W-1:0] PRG_TOP = 16'hEFFF,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hD000,
  parameter int unsigned IO_LOG2 = 12,
  parameter int unsigned VREG_LOG2 = 6
) (
  input  logic              xlate_en_i,
  input  logic              io_sw_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] phys_addr_o
);
  logic [ADDR_W:0]   prg_sum;
  logic              in_prg;
  logic              in_io;
  logic [ADDR_W-1:0] vreg_addr;

  assign prg_sum = {1'b0, cpu_addr_i} + {1'b0, PRG_OFS};
  assign in_prg  = (cpu_addr_i >= PRG_LO) && (prg_sum <= {1'b0, PRG_TOP});
  assign in_io   = cpu_addr_i[ADDR_W-1:IO_LOG2] == IO_BASE[ADDR_W-1:IO_LOG2];

  always_comb begin
    vreg_addr = '0;
    vreg_addr[VREG_LOG2-1:0] = cpu_addr_i[VREG_LOG2-1:0];
  end

  always_comb begin
    sel_o       = SEL_NONE;
    phys_addr_o = cpu_addr_i;
    if (xlate_en_i) begin
      if (in_prg) begin
        sel_o       = SEL_PRG;
        phys_addr_o = prg_sum[ADDR_W-1:0];
      end else if (in_io && io_sw_i) begin
        sel_o       = SEL_VREG;
        phys_addr_o = vreg_addr;
      end else if (in_io) begin
        sel_o       = SEL_IORAM;
      end
    end
  end
endmodule

// File: rtl/memmap_xlate.sv
module memmap_xlate
  import memmap_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h6000,
  parameter logic [ADDR_W-1:0] PRG_LO = 16'h0800,
  parameter logic [ADDR_W-1:0] PRG_OFS = 16'h5800,
  parameter logic [ADDR_W-1:0] PRG_TOP = 16'hEFFF,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hD000,
  parameter int unsigned IO_LOG2 = 12,
  parameter int unsigned VREG_LOG2 = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic              we_o,
  output logic [3:0]        cfg_o
);
  logic       xlate_en;
  logic [2:0] memcfg;

  memmap_cfg_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
  ) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i),
    .cpu_we_i(cpu_we_i), .cpu_wdata_i(cpu_wdata_i),
    .xlate_en_o(xlate_en), .memcfg_o(memcfg)
  );

  memmap_route #(
    .ADDR_W(ADDR_W), .PRG_LO(PRG_LO), .PRG_OFS(PRG_OFS), .PRG_TOP(PRG_TOP),
    .IO_BASE(IO_BASE), .IO_LOG2(IO_LOG2), .VREG_LOG2(VREG_LOG2)
  ) i_route (
    .xlate_en_i(xlate_en), .io_sw_i(memcfg[2]), .cpu_addr_i(cpu_addr_i),
    .sel_o(sel_o), .phys_addr_o(phys_addr_o)
  );

  // unbuffered: strobe passes straight to whichever target is selected
  assign we_o  = cpu_we_i && (sel_o != SEL_NONE);
  assign cfg_o = {memcfg, xlate_en};
endmodule

// File: rtl/memmap_xlate_chk.sv
module memmap_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cpu_addr_i,
  input logic        cpu_we_i,
  input logic [7:0]  cpu_wdata_i,
  input logic [3:0]  sel_o,
  input logic [15:0] phys_addr_o,
  input logic        we_o,
  input logic [3:0]  cfg_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_cfg_r1: assert (cfg_o == 4'b0000);
  end

  p_off_none_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_o[0] |-> sel_o == 4'b1000);

  p_sel_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_o) == 1);

  p_prg_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[0] |-> phys_addr_o == cpu_addr_i + 16'h5800);

  p_io_switch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[0] && cfg_o[3] && cpu_addr_i[15:12] == 4'hD) |-> sel_o == 4'b0010);

  p_vreg_mirror_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[1] |-> phys_addr_o == {10'b0, cpu_addr_i[5:0]});

  p_io_ram_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[0] && !cfg_o[3] && cpu_addr_i[15:12] == 4'hD) |->
      (sel_o == 4'b0100 && phys_addr_o == cpu_addr_i));

  p_we_direct_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o == (cpu_we_i && !sel_o[3]));

  p_ctrl_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_o[0] && cpu_we_i && cpu_addr_i == 16'h6000) |=>
      cfg_o == {$past(cpu_wdata_i[2:0]), $past(cpu_wdata_i[0])});

  p_cfg_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[0] |=> $stable(cfg_o));

  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_we_i && cpu_addr_i == 16'h6000) |=> $stable(cfg_o));
endmodule

bind memmap_xlate memmap_xlate_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i), .cpu_we_i(cpu_we_i),
  .cpu_wdata_i(cpu_wdata_i), .sel_o(sel_o), .phys_addr_o(phys_addr_o),
  .we_o(we_o), .cfg_o(cfg_o)
);

// File: tb/test_memmap_xlate.sv
module test_memmap_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [3:0]  sel;
  logic [15:0] phys;
  logic        we_out;
  logic [3:0]  cfg;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  logic [15:0] edges [10] = '{16'h07FF, 16'h0800, 16'h97FF, 16'h9800, 16'hCFFF,
                              16'hD000, 16'hD03F, 16'hD040, 16'hDFFF, 16'hE000};

  always #10 clk = ~clk;

  memmap_xlate i_memmap_xlate (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_we_i(we),
    .cpu_wdata_i(wdata), .sel_o(sel), .phys_addr_o(phys), .we_o(we_out),
    .cfg_o(cfg)
  );

  function automatic logic [3:0] exp_sel(bit en, bit io_sw, logic [15:0] a);
    if (!en) return 4'b1000;
    if (a >= 16'h0800 && a <= 16'h97FF) return 4'b0001;
    if (a >= 16'hD000 && a <= 16'hDFFF) return io_sw ? 4'b0010 : 4'b0100;
    return 4'b1000;
  endfunction

  function automatic logic [15:0] exp_phys(bit en, bit io_sw, logic [15:0] a);
    logic [3:0] s = exp_sel(en, io_sw, a);
    if (s == 4'b0001) return a + 16'h5800;
    if (s == 4'b0010) return a % 64;
    return a;
  endfunction

  task automatic chk_cfg(string req, logic [3:0] exp);
    n_vec++;
    if (cfg !== exp) begin
      n_bad++;
      $display("FAIL %s cfg got %b exp %b", req, cfg, exp);
    end
  endtask

  // drive at falling edge, sample mid-low-phase
  task automatic route(string req, bit en, bit io_sw, logic [15:0] a, bit w);
    logic [3:0] es;
    logic [15:0] ep;
    logic ew;
    @(negedge clk);
    addr = a; we = w; wdata = 8'h00;
    #3;
    es = exp_sel(en, io_sw, a);
    ep = exp_phys(en, io_sw, a);
    ew = w && (es != 4'b1000);
    n_vec++;
    if (sel !== es || phys !== ep || we_out !== ew) begin
      n_bad++;
      $display("FAIL %s addr %h got sel %b phys %h we %b exp sel %b phys %h we %b",
               req, a, sel, phys, we_out, es, ep, ew);
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 16'h0000;
    #3;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #3;
  endtask

  function automatic logic [15:0] rnd_addr();
    int unsigned k = $urandom_range(0, 3);
    if (k == 0) return $urandom_range(0, 16'hFFFF);
    return edges[$urandom_range(0, 9)] + 16'($urandom_range(0, 2)) - 16'd1;
  endfunction

  task automatic sweep(string req, bit en, bit io_sw);
    foreach (edges[i]) route(req, en, io_sw, edges[i], 1'b0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    chk_cfg("R1", 4'b0000);
    sweep("R1", 1'b0, 1'b0);
    route("R6", 1'b0, 1'b0, 16'hD000, 1'b1);

    // R9: random writes away from the control address
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a = rnd_addr();
      if (a == 16'h6000) a = 16'h6001;
      bus_write(a, 8'($urandom));
    end
    chk_cfg("R9", 4'b0000);

    // R7: enable with I/O switch set
    bus_write(16'h6000, 8'h05);
    chk_cfg("R7", 4'b1011);
    sweep("R2", 1'b1, 1'b1);
    route("R3", 1'b1, 1'b1, 16'hFFFF, 1'b0);
    route("R3", 1'b1, 1'b1, 16'h0000, 1'b0);
    route("R4", 1'b1, 1'b1, 16'hD7C5, 1'b0);
    for (int i = 0; i < 3000; i++)
      route("R6", 1'b1, 1'b1, rnd_addr(), 1'($urandom));

    // R8: control address now belongs to relocated RAM
    route("R8", 1'b1, 1'b1, 16'h6000, 1'b1);
    bus_write(16'h6000, 8'h00);
    chk_cfg("R8", 4'b1011);

    // R5: I/O switch clear
    do_reset();
    chk_cfg("R1", 4'b0000);
    bus_write(16'h6000, 8'h01);
    chk_cfg("R7", 4'b0011);
    sweep("R5", 1'b1, 1'b0);
    for (int i = 0; i < 2000; i++)
      route("R5", 1'b1, 1'b0, rnd_addr(), 1'($urandom));

    // R10: LORAM/HIRAM bits set, routing unchanged
    do_reset();
    bus_write(16'h6000, 8'h07);
    chk_cfg("R10", 4'b1111);
    sweep("R10", 1'b1, 1'b1);
    do_reset();
    bus_write(16'h6000, 8'h03);
    chk_cfg("R10", 4'b0111);
    sweep("R10", 1'b1, 1'b0);
    for (int i = 0; i < 1000; i++)
      route("R10", 1'b1, 1'b0, rnd_addr(), 1'($urandom));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule